// File: doc/BRIEF.md
# Three-Group Masked Interrupt Controller

This block collects interrupt sources from on-chip peripherals into three 8-bit groups. Two groups feed the CPU's normal interrupt line and one feeds the fast interrupt line. Each group has three registers. The status register shows the live or latched condition of each source. The mask register is writable by firmware. The request register is the AND of the two. The normal interrupt output is a registered OR of every request bit in the first two groups. The fast interrupt output is a registered OR of the fast group's request bits.

Most sources are levels that appear in status exactly as driven. In the first group, bits 2 to 6 are pulse-type events: frame flyback, ring indicate, power-on reset, and the two timer underflows. Each of these sets a latch on a rising edge, and the latch holds until firmware writes a one to that bit at the first group's request offset. Bit 7 of the first group and bit 7 of the fast group read as 1 at all times, so firmware can always raise an interrupt by unmasking that bit.

Registers are reached through a simple byte-wide port with a combinational read path and a one-cycle write strobe.

Top module: `tgic_top`

## Requirements
- R1: Reads return group A status at 0x10, request at 0x14 and mask at 0x18; group B uses 0x20, 0x24 and 0x28; group F uses 0x30, 0x34 and 0x38. The read data follows the address in the same cycle.
- R2: A write to 0x18, 0x28 or 0x38 loads that group's mask on the clock edge. Writes to 0x10, 0x20, 0x24, 0x30 and 0x34 change nothing.
- R3: Every request value equals its group's status AND its group's mask.
- R4: Status bit 7 of group A and status bit 7 of group F always read 1. Group B bit 7 follows its source.
- R5: Level bits appear in status in the same cycle their source changes. These are group A bits 0 and 1, all of group B, and group F bits 0 to 6.
- R6: Group A bits 2 to 6 set on a rising edge of their source, one clock later. They stay set after the source falls.
- R7: A write to 0x14 clears each group A latch in bits 2 to 6 whose data bit is 1. A latch whose data bit is 0 is left unchanged. Data bits 0, 1 and 7 have no effect.
- R8: If a clear and a new rising edge hit the same latch in the same cycle, the latch ends set.
- R9: irqOut equals the OR of all group A and group B request bits, delayed by one clock.
- R10: fiqOut equals the OR of all group F request bits, delayed by one clock.
- R11: After reset all masks are 0, the group A bit 4 (power-on) latch is set, the other latches are clear, and both outputs are 0.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register offset for reads and writes |
| wrEn | input | 1 | Write strobe, sampled on the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| srcA | input | 8 | Group A sources; bits 2 to 6 are pulse events |
| srcB | input | 8 | Group B level sources |
| srcF | input | 8 | Group F level sources |
| irqOut | output | 1 | Registered normal interrupt to the CPU |
| fiqOut | output | 1 | Registered fast interrupt to the CPU |

## Verification
The delicate overlap is a firmware clear at offset 0x14 landing in the same clock as a new rising edge on a group A pulse source. A second overlap is a mask write landing in the same cycle the output register samples the old mask. The bench provokes the clear/edge collision directly and requires the latch to survive. Random stimulus then mixes clears, mask writes and toggling sources every cycle. A bench model that applies the clear before the edge-set, and evaluates the output from pre-edge mask values, judges every read and both outputs in every cycle.

// File: rtl/tgic_pkg.sv
package tgic_pkg;

  localparam logic [7:0] OFF_STA  = 8'h10;
  localparam logic [7:0] OFF_REQA = 8'h14;
  localparam logic [7:0] OFF_MSKA = 8'h18;
  localparam logic [7:0] OFF_STB  = 8'h20;
  localparam logic [7:0] OFF_REQB = 8'h24;
  localparam logic [7:0] OFF_MSKB = 8'h28;
  localparam logic [7:0] OFF_STF  = 8'h30;
  localparam logic [7:0] OFF_REQF = 8'h34;
  localparam logic [7:0] OFF_MSKF = 8'h38;

  // strobes from decode to datapath
  typedef struct packed {
    logic mskA;
    logic mskB;
    logic mskF;
    logic clrA;
  } strb_t;

  typedef enum logic [3:0] {
    RS_NONE, RS_STA, RS_REQA, RS_MSKA,
    RS_STB, RS_REQB, RS_MSKB,
    RS_STF, RS_REQF, RS_MSKF
  } rsel_t;

endpackage

// File: rtl/tgic_ctrl.sv
module tgic_ctrl
  import tgic_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  output strb_t         stb,
  output rsel_t         rdSel
);

  always_comb begin
    stb   = '0;
    rdSel = RS_NONE;
    case (addr)
      AW'(OFF_STA):  rdSel = RS_STA;
      AW'(OFF_REQA): begin rdSel = RS_REQA; stb.clrA = wrEn; end
      AW'(OFF_MSKA): begin rdSel = RS_MSKA; stb.mskA = wrEn; end
      AW'(OFF_STB):  rdSel = RS_STB;
      AW'(OFF_REQB): rdSel = RS_REQB;
      AW'(OFF_MSKB): begin rdSel = RS_MSKB; stb.mskB = wrEn; end
      AW'(OFF_STF):  rdSel = RS_STF;
      AW'(OFF_REQF): rdSel = RS_REQF;
      AW'(OFF_MSKF): begin rdSel = RS_MSKF; stb.mskF = wrEn; end
      default: ;
    endcase
  end

endmodule

// File: rtl/tgic_dp.sv
module tgic_dp
  import tgic_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] EDGE_A  = 8'h7C,
  parameter logic [DW-1:0] FORCE_A = 8'h80,
  parameter logic [DW-1:0] FORCE_F = 8'h80,
  parameter int          POR_BIT = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] srcA,
  input  logic [DW-1:0] srcB,
  input  logic [DW-1:0] srcF,
  input  logic [DW-1:0] wrData,
  input  strb_t         stb,
  input  rsel_t         rdSel,
  output logic [DW-1:0] rdData,
  output logic          irqOut,
  output logic          fiqOut,
  output logic [DW-1:0] statA,
  output logic [DW-1:0] statB,
  output logic [DW-1:0] statF,
  output logic [DW-1:0] maskA,
  output logic [DW-1:0] maskB,
  output logic [DW-1:0] maskF
);

  localparam int          NGRP     = 3;
  localparam logic [DW-1:0] LAT_INIT = DW'(1) << POR_BIT;
  localparam logic [DW-1:0] LEVEL_A  = ~(EDGE_A | FORCE_A);

  logic [DW-1:0] prevA, latA, riseA, clrVec;
  logic [DW-1:0] reqA, reqB, reqF;
  logic [DW-1:0] maskR [NGRP];
  logic [NGRP-1:0] maskWe;

  // pulse-type sources: rising-edge detect, clear applied before set
  assign riseA  = srcA & ~prevA & EDGE_A;
  assign clrVec = stb.clrA ? (wrData & EDGE_A) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= '0;
      latA  <= LAT_INIT;
    end else begin
      prevA <= srcA;
      latA  <= (latA & ~clrVec) | riseA;
    end
  end

  // mask registers, one per group
  assign maskWe = {stb.mskF, stb.mskB, stb.mskA};

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)          maskR[g] <= '0;
      else if (maskWe[g]) maskR[g] <= wrData;
    end
  end

  assign maskA = maskR[0];
  assign maskB = maskR[1];
  assign maskF = maskR[2];

  // status composition
  assign statA = (latA & EDGE_A) | (srcA & LEVEL_A) | FORCE_A;
  assign statB = srcB;
  assign statF = (srcF & ~FORCE_F) | FORCE_F;

  assign reqA = statA & maskA;
  assign reqB = statB & maskB;
  assign reqF = statF & maskF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |reqA || |reqB;
      fiqOut <= |reqF;
    end
  end

  always_comb begin
    case (rdSel)
      RS_STA:  rdData = statA;
      RS_REQA: rdData = reqA;
      RS_MSKA: rdData = maskA;
      RS_STB:  rdData = statB;
      RS_REQB: rdData = reqB;
      RS_MSKB: rdData = maskB;
      RS_STF:  rdData = statF;
      RS_REQF: rdData = reqF;
      RS_MSKF: rdData = maskF;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/tgic_top.sv
module tgic_top
  import tgic_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter logic [DW-1:0] EDGE_A  = 8'h7C,
  parameter logic [DW-1:0] FORCE_A = 8'h80,
  parameter logic [DW-1:0] FORCE_F = 8'h80,
  parameter int          POR_BIT = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] srcA,
  input  logic [DW-1:0] srcB,
  input  logic [DW-1:0] srcF,
  output logic          irqOut,
  output logic          fiqOut
);

  strb_t stb;
  rsel_t rdSel;
  logic [DW-1:0] statA, statB, statF, maskA, maskB, maskF;

  tgic_ctrl #(.AW(AW)) u_ctrl (
    .addr  (addr),
    .wrEn  (wrEn),
    .stb   (stb),
    .rdSel (rdSel)
  );

  tgic_dp #(
    .DW(DW), .EDGE_A(EDGE_A), .FORCE_A(FORCE_A),
    .FORCE_F(FORCE_F), .POR_BIT(POR_BIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcA   (srcA),
    .srcB   (srcB),
    .srcF   (srcF),
    .wrData (wrData),
    .stb    (stb),
    .rdSel  (rdSel),
    .rdData (rdData),
    .irqOut (irqOut),
    .fiqOut (fiqOut),
    .statA  (statA),
    .statB  (statB),
    .statF  (statF),
    .maskA  (maskA),
    .maskB  (maskB),
    .maskF  (maskF)
  );

endmodule

// File: rtl/tgic_chk.sv
module tgic_chk
  import tgic_pkg::*;
#(
  parameter int          AW     = 8,
  parameter int          DW     = 8,
  parameter logic [DW-1:0] EDGE_A = 8'h7C
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] addr,
  input logic          wrEn,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdData,
  input logic [DW-1:0] srcA,
  input logic          irqOut,
  input logic          fiqOut,
  input logic [DW-1:0] statA,
  input logic [DW-1:0] statB,
  input logic [DW-1:0] statF,
  input logic [DW-1:0] maskA,
  input logic [DW-1:0] maskB,
  input logic [DW-1:0] maskF
);

  logic [DW-1:0] prevQ, riseQ, holdQ;
  logic clrNow;

  assign clrNow = wrEn && (addr == AW'(OFF_REQA));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      riseQ <= '0;
      holdQ <= '0;
    end else begin
      prevQ <= srcA;
      riseQ <= srcA & ~prevQ & EDGE_A;
      holdQ <= statA & EDGE_A & ~(clrNow ? wrData : '0);
    end
  end

  AST_FORCED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (addr == AW'(OFF_STA) || addr == AW'(OFF_STF)) |-> rdData[DW-1]); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((holdQ & ~statA) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((riseQ & ~statA) == '0)); // R8

  AST_MASK_LOAD_A: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && wrEn && addr == AW'(OFF_MSKA)) |-> maskA == $past(wrData)); // R2

  AST_MASK_LOAD_F: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && wrEn && addr == AW'(OFF_MSKF)) |-> maskF == $past(wrData)); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> irqOut == $past(|((statA & maskA) | (statB & maskB)))); // R9

  AST_FIQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> fiqOut == $past(|(statF & maskF))); // R10

endmodule

bind tgic_top tgic_chk #(.AW(AW), .DW(DW), .EDGE_A(EDGE_A)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .srcA(srcA), .irqOut(irqOut), .fiqOut(fiqOut),
  .statA(statA), .statB(statB), .statF(statF),
  .maskA(maskA), .maskB(maskB), .maskF(maskF)
);

// File: tb/tgic_top_tb.sv
module tgic_top_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic [7:0] addr, wrData, srcA, srcB, srcF;
  logic       wrEn;
  logic [7:0] rdData;
  logic       irqOut, fiqOut;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [7:0] mA, mB, mF, lat, prevA;
  logic       irqE, fiqE;

  tgic_top u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .srcA(srcA), .srcB(srcB), .srcF(srcF),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic logic [7:0] stA();
    return (lat & 8'h7C) | (srcA & 8'h03) | 8'h80;
  endfunction

  function automatic logic [7:0] stF();
    return srcF | 8'h80;
  endfunction

  function automatic logic [7:0] expRd(input logic [7:0] a);
    case (a)
      8'h10: return stA();
      8'h14: return stA() & mA;
      8'h18: return mA;
      8'h20: return srcB;
      8'h24: return srcB & mB;
      8'h28: return mB;
      8'h30: return stF();
      8'h34: return stF() & mF;
      8'h38: return mF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, check before posedge, advance model at posedge
  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] sa, input logic [7:0] sb, input logic [7:0] sf,
                      input string req);
    addr = a; wrEn = we; wrData = wd; srcA = sa; srcB = sb; srcF = sf;
    #1;
    chk(req, rdData, expRd(a));
    chk("R9 irqOut", {7'd0, irqOut}, {7'd0, irqE});
    chk("R10 fiqOut", {7'd0, fiqOut}, {7'd0, fiqE});
    @(posedge clk);
    irqE = |((stA() & mA) | (srcB & mB));
    fiqE = |(stF() & mF);
    if (we && a == 8'h14) lat = lat & ~(wd & 8'h7C);
    lat   = lat | (srcA & ~prevA & 8'h7C);
    prevA = srcA;
    if (we && a == 8'h18) mA = wd;
    if (we && a == 8'h28) mB = wd;
    if (we && a == 8'h38) mF = wd;
    @(negedge clk);
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a; wrEn = 1'b0;
    #1;
    chk(req, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] offs [11];
    void'($urandom(32'd2024));
    offs = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h00};
    rstN = 1'b0; addr = '0; wrEn = 1'b0; wrData = '0;
    srcA = '0; srcB = '0; srcF = '0;
    mA = '0; mB = '0; mF = '0; lat = 8'h10; prevA = '0; irqE = 1'b0; fiqE = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    peek(8'h10, 8'h90, "R11 status A after reset");
    peek(8'h18, 8'h00, "R11 mask A");
    peek(8'h28, 8'h00, "R11 mask B");
    peek(8'h38, 8'h00, "R11 mask F");
    chk("R11 outputs", {6'd0, irqOut, fiqOut}, 8'h00);
    peek(8'h30, 8'h80, "R4 group F bit7");
    peek(8'h20, 8'h00, "R4 group B bit7 follows source");

    // R7 clear power-on latch
    step(8'h14, 1'b1, 8'h10, 8'h00, 8'h00, 8'h00, "R7");
    peek(8'h10, 8'h80, "R7 power-on latch cleared");

    // R6 edge capture and hold
    step(8'h00, 1'b0, 8'h00, 8'h04, 8'h00, 8'h00, "R6");
    step(8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R6");
    peek(8'h10, 8'h84, "R6 latch held after source fell");

    // R7 zero bits and non-edge bits leave latches alone
    step(8'h14, 1'b1, 8'h08, 8'h00, 8'h00, 8'h00, "R7");
    peek(8'h10, 8'h84, "R7 zero data bit keeps latch");
    step(8'h14, 1'b1, 8'h83, 8'h00, 8'h00, 8'h00, "R7");
    peek(8'h10, 8'h84, "R7 non-edge data bits ignored");

    // R8 clear and new edge together
    step(8'h14, 1'b1, 8'h08, 8'h08, 8'h00, 8'h00, "R8");
    peek(8'h10, 8'h8C, "R8 new edge beats clear");

    // R5 level sources
    step(8'h00, 1'b0, 8'h00, 8'h03, 8'h55, 8'h11, "R5");
    peek(8'h10, 8'h8F, "R5 group A levels");
    peek(8'h20, 8'h55, "R5 group B levels");
    peek(8'h30, 8'h91, "R5 group F levels");

    // R2 writes to read-only offsets ignored
    step(8'h10, 1'b1, 8'hFF, 8'h03, 8'h55, 8'h11, "R2");
    step(8'h20, 1'b1, 8'hFF, 8'h03, 8'h55, 8'h11, "R2");
    step(8'h24, 1'b1, 8'hFF, 8'h03, 8'h55, 8'h11, "R2");
    step(8'h34, 1'b1, 8'hFF, 8'h03, 8'h55, 8'h11, "R2");
    peek(8'h18, 8'h00, "R2 mask A untouched");
    peek(8'h28, 8'h00, "R2 mask B untouched");
    peek(8'h38, 8'h00, "R2 mask F untouched");

    // R3 / R9 request and irq
    step(8'h18, 1'b1, 8'h04, 8'h03, 8'h55, 8'h11, "R2");
    peek(8'h14, 8'h04, "R3 request A");
    step(8'h00, 1'b0, 8'h00, 8'h03, 8'h55, 8'h11, "R9");
    chk("R9 irq from group A", {7'd0, irqOut}, 8'h01);

    // R10 forced bit drives fiq
    step(8'h38, 1'b1, 8'h80, 8'h03, 8'h55, 8'h11, "R10");
    step(8'h00, 1'b0, 8'h00, 8'h03, 8'h55, 8'h11, "R10");
    chk("R10 fiq from forced bit", {7'd0, fiqOut}, 8'h01);
    peek(8'h34, 8'h80, "R3 request F");

    // R12 unmapped reads
    peek(8'h3C, 8'h00, "R12 unmapped 0x3C");
    peek(8'h00, 8'h00, "R12 unmapped 0x00");
    peek(8'h44, 8'h00, "R12 unmapped 0x44");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic       we;
      a  = offs[$urandom_range(0, 10)];
      we = ($urandom_range(0, 2) == 0);
      step(a, we, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R1 random read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule